// File: doc/BRIEF.md
# DiSEqC Tone Message Encoder

This block drives the control signalling toward satellite outdoor equipment by gating an external 22 kHz carrier on and off in timed patterns. A host places up to `MAX_BYTES` message bytes and a byte count on the inputs, then pulses `start`. The block shapes every bit as three equal ticks whose on/off proportion codes the bit value. Each byte is followed by a generated odd-parity bit. A separate burst mode holds the carrier on for a fixed span.

The carrier itself is never produced here. `carrier_en` switches an external oscillator, and `data_level` presents the logical value of the bit in flight as a second, separate line. `busy` covers the whole transmission, and `done` marks its end. With the default parameters a 4 MHz clock gives a 500 us tick, which is 2000 clocks.

Top module: `dseq_tone_encoder`

## Requirements
- R1: One tick lasts `TICK_CYCLES` clocks, and each bit lasts exactly three ticks, counted from the first cycle in which `busy` is high.
- R2: A bit of value 0 keeps `carrier_en` high for the first two ticks of its period and low for the third.
- R3: A bit of value 1 keeps `carrier_en` high for the first tick of its period and low for the last two.
- R4: Byte k is taken from `msg_data[8k+7:8k]`, and bytes go out in increasing k. Within a byte, bit 7 is sent first.
- R5: After the eight data bits of each byte a ninth bit is sent, chosen so that the nine bits hold an odd number of ones.
- R6: When `burst_mode` is high at the start pulse, `carrier_en` stays high for 25 consecutive ticks, `data_level` stays low and the message inputs are not used.
- R7: During a message, `data_level` equals the value of the bit currently being sent for all three of its ticks. It is low when idle and during a burst.
- R8: `busy` rises in the cycle after an accepted start and falls in the cycle after the last tick ends. In that first cycle with `busy` low, `done` is high for exactly one clock.
- R9: A `start` pulse that arrives while `busy` is high has no effect.
- R10: A message start with a byte count of zero raises `done` for one clock in the next cycle. `busy` never rises and `carrier_en` never rises.
- R11: A byte count above `MAX_BYTES` is treated as `MAX_BYTES`.
- R12: `carrier_en` is low whenever `busy` is low. It is low in the cycle after any clock edge at which `rst_n` is low.
- R13: Changes to `msg_data`, `msg_len` or `burst_mode` after an accepted start do not alter the transmission in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick is `TICK_CYCLES` periods |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transmission |
| burst_mode | input | 1 | At start: 1 sends a tone burst, 0 sends the message |
| msg_len | input | clog2(MAX_BYTES+1) | Number of message bytes |
| msg_data | input | 8*MAX_BYTES | Message bytes, byte 0 in the low bits |
| carrier_en | output | 1 | Gate for the external 22 kHz carrier |
| data_level | output | 1 | Logical value of the bit being sent |
| busy | output | 1 | High while a transmission is running |
| done | output | 1 | One-cycle pulse when a transmission ends |

## Verification
The bench builds the block with `TICK_CYCLES` = 4 and `MAX_BYTES` = 5. The short tick keeps every byte to 108 clocks, so messages of every length, back-to-back runs and full 25-tick bursts all fit in a short run. Because the byte count is three bits wide, counts of 6 and 7 can be applied, which exercises the clamp to the maximum. The reference model turns each start into a queue of per-tick gate and data levels, and the bench compares it against all four outputs on every clock, including across a reset applied in mid-message.

// File: rtl/dseq_pkg.sv
// Package: shared definitions for the tone message encoder.
// Holds the sequencer state type, the fixed framing constants and the
// parity helper. Assumes byte-wide symbols and one parity bit per byte.
package dseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MSG   = 2'd1,
        ST_BURST = 2'd2
    } dseq_state_e;

    localparam int TICKS_PER_BIT  = 3;
    localparam int BITS_PER_FRAME = 9;
    localparam int BURST_TICKS    = 25;

    // Returns the ninth bit that makes a byte plus that bit odd in ones.
    function automatic logic odd_parity(input logic [7:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/dseq_tick_gen.sv
// Module: tick prescaler.
// Emits a one-cycle tick every TICK_CYCLES clocks while run is high.
// The count is cleared whenever run is low, so the first tick after run
// rises comes exactly TICK_CYCLES clocks later.
module dseq_tick_gen #(
    parameter int TICK_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Free-running divider, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/dseq_symbol.sv
// Module: bit-symbol shaper.
// Walks the three ticks of one bit period and produces the carrier gate:
// a 0 is two ticks on and one off, a 1 is one tick on and two off.
// Assumes bit_val stays stable for a whole period and tick comes from the
// prescaler.
module dseq_symbol (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic bit_val,
    output logic gate,
    output logic sym_end
);
    import dseq_pkg::*;

    localparam logic [1:0] PH_LAST = 2'(TICKS_PER_BIT - 1);

    logic [1:0] phase;

    // Tick position inside the current bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
        end else if (tick) begin
            phase <= (phase == PH_LAST) ? 2'd0 : phase + 2'd1;
        end
    end

    assign gate    = run && ((phase == 2'd0) || ((phase == 2'd1) && !bit_val));
    assign sym_end = run && tick && (phase == PH_LAST);

endmodule

// File: rtl/dseq_frame.sv
// Module: byte and bit sequencer.
// Latches the message at load time, then presents the bits one at a time:
// eight data bits from MSB to LSB, then the odd-parity bit. Bytes go out
// from index 0 upward. Assumes load_len is at least 1 and at most MAX_BYTES.
module dseq_frame #(
    parameter int MAX_BYTES = 6,
    localparam int LEN_W  = $clog2(MAX_BYTES + 1),
    localparam int IDX_W  = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    localparam int DATA_W = MAX_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LEN_W-1:0]  load_len,
    input  logic [DATA_W-1:0] load_data,
    input  logic              sym_end,
    output logic              cur_bit,
    output logic              frame_last
);
    import dseq_pkg::*;

    localparam logic [3:0] PAR_POS = 4'(BITS_PER_FRAME - 1);

    logic [DATA_W-1:0] data_q;
    logic [7:0]        byte_arr [MAX_BYTES];
    logic [IDX_W-1:0]  byte_idx;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  nxt_idx;
    logic [3:0]        bit_idx;
    logic [7:0]        shreg;
    logic              par_q;
    logic [7:0]        nxt_byte;

    // Byte view of the latched message.
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_bytes
        assign byte_arr[g] = data_q[g*8 +: 8];
    end

    assign nxt_idx  = byte_idx + 1'b1;
    assign nxt_byte = byte_arr[nxt_idx];

    // Message store, byte pointer, bit pointer and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            byte_idx <= '0;
            last_idx <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_q    <= 1'b0;
        end else if (load) begin
            data_q   <= load_data;
            byte_idx <= '0;
            last_idx <= IDX_W'(load_len - LEN_W'(1));
            bit_idx  <= '0;
            shreg    <= load_data[7:0];
            par_q    <= odd_parity(load_data[7:0]);
        end else if (sym_end) begin
            if (bit_idx == PAR_POS) begin
                if (byte_idx != last_idx) begin
                    byte_idx <= nxt_idx;
                    shreg    <= nxt_byte;
                    par_q    <= odd_parity(nxt_byte);
                    bit_idx  <= '0;
                end
            end else begin
                shreg   <= {shreg[6:0], 1'b0};
                bit_idx <= bit_idx + 4'd1;
            end
        end
    end

    assign cur_bit    = (bit_idx == PAR_POS) ? par_q : shreg[7];
    assign frame_last = sym_end && (bit_idx == PAR_POS) && (byte_idx == last_idx);

endmodule

// File: rtl/dseq_tone_encoder.sv
// Module: top of the tone message encoder.
// Accepts a start pulse while idle and runs either a message (bytes with
// parity, three-tick symbols) or a 25-tick tone burst. It drives the
// carrier gate, the data level, busy and a one-cycle done pulse. Starts
// during a run are ignored, and inputs are sampled only at the start.
module dseq_tone_encoder #(
    parameter int TICK_CYCLES = 2000,
    parameter int MAX_BYTES   = 6,
    localparam int LEN_W  = $clog2(MAX_BYTES + 1),
    localparam int DATA_W = MAX_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              burst_mode,
    input  logic [LEN_W-1:0]  msg_len,
    input  logic [DATA_W-1:0] msg_data,
    output logic              carrier_en,
    output logic              data_level,
    output logic              busy,
    output logic              done
);
    import dseq_pkg::*;

    localparam logic [LEN_W-1:0] LEN_MAX    = LEN_W'(MAX_BYTES);
    localparam logic [4:0]       BURST_LAST = 5'(BURST_TICKS - 1);

    dseq_state_e      state;
    logic [4:0]       burst_cnt;
    logic             done_q;
    logic [LEN_W-1:0] eff_len;
    logic             accept;
    logic             load_msg;
    logic             tick;
    logic             sym_gate;
    logic             sym_end;
    logic             cur_bit;
    logic             frame_last;

    assign eff_len  = (msg_len > LEN_MAX) ? LEN_MAX : msg_len;
    assign accept   = (state == ST_IDLE) && start;
    assign load_msg = accept && !burst_mode && (eff_len != '0);

    dseq_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state != ST_IDLE),
        .tick (tick)
    );

    dseq_symbol u_sym (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_MSG),
        .tick   (tick),
        .bit_val(cur_bit),
        .gate   (sym_gate),
        .sym_end(sym_end)
    );

    dseq_frame #(.MAX_BYTES(MAX_BYTES)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_msg),
        .load_len  (eff_len),
        .load_data (msg_data),
        .sym_end   (sym_end),
        .cur_bit   (cur_bit),
        .frame_last(frame_last)
    );

    // Run control: start acceptance, burst timing and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            burst_cnt <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (burst_mode) begin
                            state     <= ST_BURST;
                            burst_cnt <= '0;
                        end else if (eff_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state <= ST_MSG;
                        end
                    end
                end
                ST_MSG: begin
                    if (frame_last) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                ST_BURST: begin
                    if (tick) begin
                        if (burst_cnt == BURST_LAST) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            burst_cnt <= burst_cnt + 5'd1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign done       = done_q;
    assign carrier_en = (state == ST_BURST) || sym_gate;
    assign data_level = (state == ST_MSG) && cur_bit;

endmodule

// File: rtl/dseq_tone_encoder_chk.sv
// Module: protocol checker bound to the encoder top; observes ports only.
module dseq_tone_encoder_chk #(
    parameter int LEN_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             burst_mode,
    input logic [LEN_W-1:0] msg_len,
    input logic             carrier_en,
    input logic             data_level,
    input logic             busy,
    input logic             done
);
    // R12
    carrier_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !carrier_en);

    // R12
    reset_gate_chk: assert property (@(posedge clk)
        !rst_n |=> !carrier_en);

    // R8
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(rst_n)) |-> done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    data_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_level |-> busy);

    // R10
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !burst_mode && (msg_len == '0)) |=> (!busy && done && !carrier_en));

    // R6
    burst_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && burst_mode) |=> (busy && carrier_en && !data_level));

endmodule

bind dseq_tone_encoder dseq_tone_encoder_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .burst_mode(burst_mode),
    .msg_len   (msg_len),
    .carrier_en(carrier_en),
    .data_level(data_level),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_dseq_tone_encoder.sv
module tb_dseq_tone_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int TB_TICK    = 4;
    localparam int TB_MAX     = 5;
    localparam int LW         = $clog2(TB_MAX + 1);
    localparam int DW         = TB_MAX * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          burst_mode = 1'b0;
    logic [LW-1:0] msg_len = '0;
    logic [DW-1:0] msg_data = '0;
    logic          carrier_en, data_level, busy, done;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    // Model state: one {gate,data} entry per tick still to send.
    logic [1:0] q[$];
    bit         m_busy = 1'b0;
    bit         m_done = 1'b0;
    int         m_cnt  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dseq_tone_encoder #(.TICK_CYCLES(TB_TICK), .MAX_BYTES(TB_MAX)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .burst_mode(burst_mode),
        .msg_len(msg_len), .msg_data(msg_data), .carrier_en(carrier_en),
        .data_level(data_level), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_busy = 1'b0;
            m_done = 1'b0;
            m_cnt  = 0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == TB_TICK) begin
                    m_cnt = 0;
                    void'(q.pop_front());
                    if (q.size() == 0) begin
                        m_busy = 1'b0;
                        m_done = 1'b1;
                    end
                end
            end else if (start) begin
                if (burst_mode) begin
                    for (int i = 0; i < 25; i++) q.push_back(2'b10);
                end else begin
                    int n;
                    n = (int'(msg_len) > TB_MAX) ? TB_MAX : int'(msg_len);
                    for (int i = 0; i < n; i++) begin
                        logic [7:0] b;
                        b = msg_data[i*8 +: 8];
                        for (int j = 0; j < 9; j++) begin
                            logic v;
                            v = (j < 8) ? b[7-j] : ~(^b);
                            q.push_back({1'b1, v});
                            q.push_back({~v, v});
                            q.push_back({1'b0, v});
                        end
                    end
                end
                if (q.size() == 0) m_done = 1'b1;
                else begin
                    m_busy = 1'b1;
                    m_cnt  = 0;
                end
            end
        end
    end

    // Compare all outputs against the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            logic ec, ed;
            ec = m_busy ? q[0][1] : 1'b0;
            ed = m_busy ? q[0][0] : 1'b0;
            chk(carrier_en === ec, "R1 R2 R3 R4 R5 R6 R11 R13 carrier_en", int'(carrier_en), int'(ec));
            chk(data_level === ed, "R4 R5 R7 R13 data_level", int'(data_level), int'(ed));
            chk(busy === m_busy, "R8 R9 busy", int'(busy), int'(m_busy));
            chk(done === m_done, "R8 R10 done", int'(done), int'(m_done));
        end
    end

    task automatic send(input bit bm, input logic [LW-1:0] len, input logic [DW-1:0] d);
        @(negedge clk);
        burst_mode = bm;
        msg_len    = len;
        msg_data   = d;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(carrier_en === 1'b0, "R12 reset carrier_en", int'(carrier_en), 0);
        chk(busy === 1'b0 && done === 1'b0, "R12 reset busy/done", int'(busy), 0);
        rst_n  = 1'b1;
        cmp_on = 1'b1;

        send(0, 3'd1, 40'h00);            // R2 R5: all zeros
        wait_idle();
        send(0, 3'd1, 40'hFF);            // R3 R5: all ones
        wait_idle();
        send(0, 3'd2, 40'h3CA5);          // R4: two bytes
        wait_idle();
        send(0, 3'd5, 40'h8001_7E_42_C3); // R4: full length
        wait_idle();
        send(0, 3'd7, 40'h1122334455);    // R11: clamp to maximum
        wait_idle();
        send(1, 3'd3, 40'hFFFF);          // R6: burst
        wait_idle();

        // R10: zero length finishes at once
        send(0, 3'd0, 40'hAB);
        chk(done === 1'b1, "R10 zero-length done", int'(done), 1);
        chk(busy === 1'b0 && carrier_en === 1'b0, "R10 zero-length idle", int'(busy), 0);
        wait_idle();

        // R9 R13: start and input changes during a run
        send(0, 3'd2, 40'h5A96);
        repeat (20) @(negedge clk);
        msg_data = 40'hFFFFFFFFFF;
        msg_len  = 3'd5;
        burst_mode = 1'b1;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        wait_idle();

        // R12: reset in mid-message drops the gate at the next edge
        send(0, 3'd3, 40'h00_00_00);
        repeat (9) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(carrier_en === 1'b0, "R12 gate after reset", int'(carrier_en), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        send(1, 3'd0, 40'h0);             // R6 R8: burst after reset
        wait_idle();

        cmp_on = 1'b0;
        finish_run();
    end
endmodule